// File: doc/BRIEF.md
# Vector Element Address Sequencer

This block turns one vector memory instruction into a stream of per-element addresses. A single-cycle start pulse captures an addressing mode, a base address, a signed step value and a requested element count. From the next cycle on, the block presents one address per cycle on a valid/ready output, tagged with its element number. After the last element has been accepted it raises a one-cycle completion pulse.

Four modes are supported. Contiguous mode walks 64-bit elements 8 bytes apart. Strided mode advances by a signed byte step taken from a scalar register. Gather/scatter mode adds a per-element offset, read from an index vector through a combinational read port, to the base. Sequence mode produces the arithmetic series 0, m, 2m, ... for writing into an index register, and emits the values on the same stream. The element count is limited to the maximum vector length of 64. The memory banks, the data path and the register file sit outside the block.

Top module: `vec_agu`

## Requirements
- R1: Mode code 2'b00 (contiguous) emits base + 8*e for element e.
- R2: Mode code 2'b01 (strided) emits base + e*stride, with stride taken as a signed two's-complement byte step and the sum wrapping at the address width, so negative steps walk downward.
- R3: Mode code 2'b10 (gather/scatter) drives idx_rd_addr with the element number of the address being formed and emits base + idx_rd_data for element e, with idx_rd_data read in the same cycle.
- R4: Mode code 2'b11 (sequence) emits e*m for element e, with m taken from the stride input and base ignored.
- R5: An operation produces exactly min(vlen, 64) elements, numbered 0, 1, 2, ... in ascending order on out_elem.
- R6: A start with vlen equal to zero produces no valid output and pulses done in the cycle after the start.
- R7: The first element is valid in the cycle after the start, and with out_ready held high one new element is presented every cycle.
- R8: While out_valid is high and out_ready is low, out_addr and out_elem hold their values and out_valid stays high.
- R9: done is high for exactly one cycle, the cycle after the final element's handshake, and out_valid is low in that cycle.
- R10: A start pulse that arrives while an operation is in progress is ignored; the running stream continues unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins an operation when idle |
| mode | input | 2 | Addressing mode code (see R1 to R4) |
| base | input | AW | Base byte address |
| stride | input | AW | Signed byte step, or series increment in sequence mode |
| vlen | input | LENW | Requested element count, limited to MAXVL |
| idx_rd_addr | output | log2(MAXVL) | Element number for the index vector read |
| idx_rd_data | input | AW | Index vector entry for idx_rd_addr, same cycle |
| out_valid | output | 1 | Address stream valid |
| out_ready | input | 1 | Address stream ready |
| out_addr | output | AW | Element address, or series value in sequence mode |
| out_elem | output | log2(MAXVL) | Element number of out_addr |
| done | output | 1 | One-cycle pulse when the operation completes |

## Verification
The bench goes after the length limits. A request of 100 must stop at 64 elements, or the stream overruns the vector register. A request of zero must still pulse done, or the issuing unit waits forever. A single-element gather exercises the case where the first and last handshakes coincide. Backpressure is applied in a repeating pattern during strided and gather runs: a design that advanced its counter or accumulator on a stalled cycle would skip an element. A negative step catches an unsigned step extension, which would send addresses upward. A start pulse in the middle of a stream would corrupt later addresses if it were taken as a restart.

// File: rtl/vagu_pkg.sv
package vagu_pkg;
  typedef enum logic [1:0] {
    AM_UNIT   = 2'b00,
    AM_STRIDE = 2'b01,
    AM_INDEX  = 2'b10,
    AM_SEQ    = 2'b11
  } amode_t;
endpackage

// File: rtl/vagu_ctl.sv
// Element counter, length limit, handshake and completion pulse.
module vagu_ctl #(
  parameter int MAXVL = 64,
  parameter int LENW  = 8,
  localparam int EW   = $clog2(MAXVL),
  localparam int CW   = $clog2(MAXVL + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [LENW-1:0] vlen,
  input  logic          out_ready,
  output logic          load,
  output logic          adv,
  output logic          last,
  output logic          out_valid,
  output logic [EW-1:0] out_elem,
  output logic [EW-1:0] idx_sel,
  output logic          done
);
  logic [CW-1:0] len_c;
  logic [CW-1:0] len_q;
  logic          accept;
  logic          fire;

  // Limit the requested count to the register length.
  generate
    if (LENW > CW) begin : g_wide
      always_comb len_c = (vlen > LENW'(MAXVL)) ? CW'(MAXVL) : vlen[CW-1:0];
    end else begin : g_narrow
      always_comb len_c = (CW'(vlen) > CW'(MAXVL)) ? CW'(MAXVL) : CW'(vlen);
    end
  endgenerate

  assign accept  = start && !out_valid;
  assign load    = accept && (len_c != '0);
  assign fire    = out_valid && out_ready;
  assign last    = ({1'b0, out_elem} == (len_q - CW'(1)));
  assign adv     = fire && !last;
  assign idx_sel = out_valid ? (out_elem + EW'(1)) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_elem  <= '0;
      len_q     <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        len_q <= len_c;
        if (len_c == '0) begin
          done <= 1'b1;
        end else begin
          out_valid <= 1'b1;
          out_elem  <= '0;
        end
      end else if (fire) begin
        if (last) begin
          out_valid <= 1'b0;
          done      <= 1'b1;
        end else begin
          out_elem <= out_elem + EW'(1);
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && last) |=> (done && !out_valid)); // R9
  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (rst)
    (start && !out_valid && vlen == '0) |=> (done && !out_valid)); // R6
  AST_ELEM_BOUND: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ({1'b0, out_elem} < len_q)); // R5
  AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
    (start && out_valid) |=> $stable(len_q)); // R10
endmodule

// File: rtl/vagu_dp.sv
// Address datapath: running step accumulator and per-mode address select.
module vagu_dp
  import vagu_pkg::*;
#(
  parameter int AW     = 32,
  parameter int EBYTES = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          adv,
  input  amode_t        mode,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] stride,
  input  logic [AW-1:0] idx_data,
  output logic [AW-1:0] out_addr
);
  amode_t        mode_q;
  logic [AW-1:0] base_q;
  logic [AW-1:0] step_q;
  logic [AW-1:0] acc;
  logic [AW-1:0] acc_n;
  amode_t        cur_mode;
  logic [AW-1:0] cur_base;
  logic [AW-1:0] lin_addr;
  logic [AW-1:0] nxt_addr;

  always_comb begin
    acc_n    = load ? '0 : (acc + step_q);
    cur_mode = load ? mode : mode_q;
    cur_base = load ? base : base_q;
    lin_addr = ((cur_mode == AM_SEQ) ? '0 : cur_base) + acc_n;
    nxt_addr = (cur_mode == AM_INDEX) ? (cur_base + idx_data) : lin_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= AM_UNIT;
      base_q   <= '0;
      step_q   <= '0;
      acc      <= '0;
      out_addr <= '0;
    end else if (load) begin
      mode_q   <= mode;
      base_q   <= base;
      step_q   <= (mode == AM_UNIT) ? AW'(EBYTES) : stride;
      acc      <= acc_n;
      out_addr <= nxt_addr;
    end else if (adv) begin
      acc      <= acc_n;
      out_addr <= nxt_addr;
    end
  end

  AST_ACC_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!load && !adv) |=> ($stable(acc) && $stable(out_addr))); // R8
endmodule

// File: rtl/vec_agu.sv
module vec_agu
  import vagu_pkg::*;
#(
  parameter int AW     = 32,
  parameter int MAXVL  = 64,
  parameter int LENW   = 8,
  parameter int EBYTES = 8,
  localparam int EW    = $clog2(MAXVL)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [1:0]      mode,
  input  logic [AW-1:0]   base,
  input  logic [AW-1:0]   stride,
  input  logic [LENW-1:0] vlen,
  output logic [EW-1:0]   idx_rd_addr,
  input  logic [AW-1:0]   idx_rd_data,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [AW-1:0]   out_addr,
  output logic [EW-1:0]   out_elem,
  output logic            done
);
  logic load;
  logic adv;
  logic last;
  logic unit_run;

  vagu_ctl #(.MAXVL(MAXVL), .LENW(LENW)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .vlen      (vlen),
    .out_ready (out_ready),
    .load      (load),
    .adv       (adv),
    .last      (last),
    .out_valid (out_valid),
    .out_elem  (out_elem),
    .idx_sel   (idx_rd_addr),
    .done      (done)
  );

  vagu_dp #(.AW(AW), .EBYTES(EBYTES)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .adv      (adv),
    .mode     (amode_t'(mode)),
    .base     (base),
    .stride   (stride),
    .idx_data (idx_rd_data),
    .out_addr (out_addr)
  );

  always_ff @(posedge clk) begin
    if (rst)       unit_run <= 1'b0;
    else if (load) unit_run <= (mode == AM_UNIT);
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_elem))); // R8
  AST_ELEM_STEP: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !last) |=> (out_valid && out_elem == $past(out_elem) + EW'(1))); // R5
  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !last && unit_run) |=> (out_addr == $past(out_addr) + AW'(EBYTES))); // R1
  AST_FIRST_VALID: assert property (@(posedge clk) disable iff (rst)
    (start && !out_valid && vlen != '0) |=> (out_valid && out_elem == '0)); // R7
endmodule

// File: tb/test_vec_agu.sv
module test_vec_agu;
  localparam int AW = 32;
  localparam int EW = 6;

  logic          clk = 1'b0;
  logic          rst;
  logic          start;
  logic [1:0]    mode;
  logic [AW-1:0] base;
  logic [AW-1:0] stride;
  logic [7:0]    vlen;
  logic [EW-1:0] idx_rd_addr;
  logic [AW-1:0] idx_rd_data;
  logic          out_valid;
  logic          out_ready;
  logic [AW-1:0] out_addr;
  logic [EW-1:0] out_elem;
  logic          done;

  logic [AW-1:0] idx_mem [64];
  int n_checks = 0;
  int n_fails  = 0;
  int wd       = 0;

  always #2.5 clk = ~clk;

  assign idx_rd_data = idx_mem[idx_rd_addr];

  vec_agu i_vec_agu (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .base(base),
    .stride(stride), .vlen(vlen), .idx_rd_addr(idx_rd_addr),
    .idx_rd_data(idx_rd_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_elem(out_elem), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_addr(input logic [1:0] md,
      input logic [AW-1:0] b, input logic [AW-1:0] s, input int e);
    case (md)
      2'b00:   return b + AW'(8 * e);
      2'b01:   return b + AW'(e) * s;
      2'b10:   return b + idx_mem[e];
      default: return AW'(e) * s;
    endcase
  endfunction

  // One operation: drive start, collect the stream, check every element,
  // stalls, the completion pulse and the element count.
  task automatic run_op(input string req, input logic [1:0] md,
      input logic [AW-1:0] b, input logic [AW-1:0] s, input int vl,
      input int n_exp, input bit stall, input bit poke);
    int k = 0;
    int cyc = 0;
    bit held = 0;
    logic [AW-1:0] hold_a = '0;
    logic [EW-1:0] hold_e = '0;
    @(negedge clk);
    mode = md; base = b; stride = s; vlen = 8'(vl); start = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    check(out_valid == (n_exp != 0), "R7", "valid one cycle after start",
          AW'(out_valid), AW'(n_exp != 0));
    if (n_exp == 0) begin
      check(done == 1'b1, "R6", "done after zero-length start", AW'(done), 1);
      @(negedge clk);
      check(done == 1'b0 && out_valid == 1'b0, "R6", "no output after zero length",
            AW'({done, out_valid}), 0);
      return;
    end
    while (k < n_exp && cyc < 2000) begin
      out_ready = stall ? (cyc % 3 != 1) : 1'b1;
      start = (poke && cyc == 2);
      if (poke && cyc == 2) base = b + 32'h1000;
      if (held)
        check(out_valid && out_addr == hold_a && out_elem == hold_e, "R8",
              "stalled element held", out_addr, hold_a);
      if (!stall)
        check(out_valid == 1'b1, "R7", "one element per cycle", AW'(out_valid), 1);
      held = 0;
      if (out_valid) begin
        if (out_ready) begin
          check(out_addr == exp_addr(md, b, s, k), req, "element address",
                out_addr, exp_addr(md, b, s, k));
          check(out_elem == EW'(k), "R5", "element number", AW'(out_elem), AW'(k));
          if (md == 2'b10)
            check(idx_rd_addr == EW'(k + 1), "R3", "index read follows element",
                  AW'(idx_rd_addr), AW'(EW'(k + 1)));
          k++;
        end else begin
          held = 1; hold_a = out_addr; hold_e = out_elem;
        end
      end
      @(negedge clk);
      cyc++;
    end
    out_ready = 1'b0; start = 1'b0;
    check(k == n_exp, "R5", "element count", AW'(k), AW'(n_exp));
    check(done == 1'b1 && out_valid == 1'b0, "R9", "done after final handshake",
          AW'({done, out_valid}), 32'h2);
    @(negedge clk);
    check(done == 1'b0 && out_valid == 1'b0, "R9", "done lasts one cycle",
          AW'({done, out_valid}), 0);
  endtask

  task automatic t_reset;
    check(out_valid == 1'b0 && done == 1'b0 && out_elem == '0, "R5",
          "reset state", AW'({out_valid, done, out_elem}), 0);
  endtask

  task automatic t_unit;       run_op("R1", 2'b00, 32'h0000_4000, 32'h0, 10, 10, 0, 0); endtask
  task automatic t_stride_up;  run_op("R2", 2'b01, 32'h0001_0000, 32'd24, 7, 7, 1, 0); endtask
  task automatic t_stride_dn;  run_op("R2", 2'b01, 32'h0000_0100, -32'sd16, 20, 20, 0, 0); endtask
  task automatic t_gather;     run_op("R3", 2'b10, 32'h0002_0000, 32'h0, 12, 12, 1, 0); endtask
  task automatic t_gather_one; run_op("R3", 2'b10, 32'h0000_0800, 32'h0, 1, 1, 0, 0); endtask
  task automatic t_seq;        run_op("R4", 2'b11, 32'hDEAD_0000, 32'd3, 64, 64, 0, 0); endtask
  task automatic t_clamp;      run_op("R5", 2'b00, 32'h0000_0000, 32'h0, 100, 64, 0, 0); endtask
  task automatic t_zero;       run_op("R6", 2'b01, 32'h0000_0040, 32'd8, 0, 0, 0, 0); endtask
  task automatic t_busy_start; run_op("R10", 2'b01, 32'h0000_3000, 32'd40, 6, 6, 0, 1); endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", wd);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) idx_mem[i] = AW'(i * 40) + AW'((i % 5) * 1000) - 32'd600;
    rst = 1'b1; start = 1'b0; mode = 2'b00; base = '0; stride = '0; vlen = '0;
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_unit();
    t_stride_up();
    t_stride_dn();
    t_gather();
    t_gather_one();
    t_seq();
    t_clamp();
    t_zero();
    t_busy_start();
    t_unit();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule